// File: doc/BRIEF.md
# Age-Filtered Squash Redirect Unit

This unit sits between the execute stage and the reorder buffer of an out-of-order core. It decides which redirect requests (mispredictions and other squashes) are acted on. For each hardware thread it keeps the sequence number of the youngest instruction that is still valid in the buffer. A request is acted on only when it names an instruction older than that value, because only then can its instruction still be in the buffer. If several requests qualify in the same cycle, the oldest one wins.

An accepted request is broadcast to every pipeline stage for one cycle. The broadcast carries the thread, the sequence number to squash up to, the branch target and the mispredict flag. The thread's youngest value becomes the squashing instruction's number. The thread then enters a flushing state. In that state a bounded number of buffer entries is reported as removed each cycle, until the count of entries younger than the squash point has been used up. The buffer storage and the refetch logic are outside this block.

Top module: `squash_redirect_unit`

## Requirements
- R1: After reset, every thread's youngest value is 0. Every thread is idle with no flush in progress. No broadcast is valid, every per-thread removal count is 0, the flush count is 0 and `active` is low.
- R2: When a thread is in the running state and its insert strobe is high, the thread's youngest value takes the inserted sequence number at the next edge. An insert to a thread that is idle or flushing leaves the youngest value unchanged.
- R3: A request is eligible only when its thread is enabled and its sequence number is strictly less (unsigned) than that thread's youngest value. A request that is not eligible causes no broadcast and changes no state.
- R4: At most one request is accepted per cycle. Among the eligible requests the smallest sequence number wins. On a tie, the lowest request index wins.
- R5: The broadcast is registered. It is valid for exactly one cycle, the cycle after the request, and carries the winner's thread, sequence number, target and mispredict flag.
- R6: When a request is accepted, its thread's youngest value becomes the request's sequence number and the thread enters flushing. The remaining-entry count is loaded with the request's drop count, and the thread's removal count is 0 in that first flushing cycle.
- R7: Each cycle of a flush, the removal count reported is min(remaining, RM_PER_CYC), and the remaining count drops by that amount. A flush of D entries lasts max(1, ceil(D / RM_PER_CYC)) cycles, and its removal counts sum to D.
- R8: After the removal that empties the remaining count, the thread returns to running if it is enabled, otherwise to idle. While a thread is flushing and no request is accepted for it, its youngest value holds.
- R9: An eligible request for a thread that is already flushing restarts the flush. It reloads the remaining count with the new drop count and sets the youngest value to the new sequence number.
- R10: `flush_cnt` equals the number of threads in the flushing state. `active` is high exactly when `flush_cnt` is non-zero or at least one thread is running.
- R11: A thread that is not flushing becomes running at the next edge when its enable is high, and idle when its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_en | input | NT | Per-thread enable |
| ins_v | input | NT | Per-thread insert strobe |
| ins_seq | input | NT*SEQ_W | Inserted sequence number, thread t at bits [t*SEQ_W +: SEQ_W] |
| req_v | input | NR | Redirect request valid, one bit per source |
| req_tid | input | NR*TID_W | Request thread, source r at [r*TID_W +: TID_W] |
| req_seq | input | NR*SEQ_W | Request squash-up-to sequence number |
| req_tgt | input | NR*TGT_W | Request branch target |
| req_mis | input | NR | Request mispredict flag |
| req_drop | input | NR*CNT_W | Entries younger than the squash point |
| bc_v | output | 1 | Broadcast valid |
| bc_tid | output | TID_W | Broadcast thread |
| bc_seq | output | SEQ_W | Broadcast squash-up-to sequence number |
| bc_tgt | output | TGT_W | Broadcast target |
| bc_mis | output | 1 | Broadcast mispredict flag |
| youngest | output | NT*SEQ_W | Per-thread youngest valid sequence number |
| flushing | output | NT | Per-thread flushing state |
| rm_num | output | NT*CNT_W | Per-thread entries removed this cycle |
| flush_cnt | output | FC_W | Number of threads flushing |
| active | output | 1 | Unit has work in progress |

## Verification
On every cycle, the embedded assertions check four things: every accepted request is older than its thread's youngest value, an acceptance loads the flushing state and the youngest value, removals stay within the per-cycle limit and happen only during a flush, and the youngest value holds through a flush. Other behaviours show only through the bench's scenarios: the choice of winner among competing requests and its tie-break, the exact number of flush cycles and the sum of removals, the restart of a flush by an older request, and the activity summary. The bench compares these against a cycle model built from the requirements.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_RUN   = 2'd1,
    TS_FLUSH = 2'd2
  } tstate_e;
endpackage

// File: rtl/srd_pick.sv
// Oldest-eligible selector across all redirect sources.
module srd_pick #(
  parameter int NT    = 2,
  parameter int NR    = 3,
  parameter int SEQ_W = 16,
  parameter int TID_W = 1,
  parameter int IDX_W = 2
) (
  input  logic [NR-1:0]       req_v,
  input  logic [NR*TID_W-1:0] req_tid,
  input  logic [NR*SEQ_W-1:0] req_seq,
  input  logic [NT-1:0]       en,
  input  logic [NT*SEQ_W-1:0] yng,
  output logic                pick_v,
  output logic [IDX_W-1:0]    pick_idx
);
  logic [SEQ_W-1:0] best;
  logic [TID_W-1:0] t_r;
  logic [SEQ_W-1:0] s_r;
  logic [SEQ_W-1:0] lim;
  logic             ok;

  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    best     = '0;
    t_r      = '0;
    s_r      = '0;
    lim      = '0;
    ok       = 1'b0;
    for (int r = 0; r < NR; r++) begin
      t_r = req_tid[r*TID_W +: TID_W];
      s_r = req_seq[r*SEQ_W +: SEQ_W];
      ok  = (int'(t_r) < NT);
      lim = ok ? yng[int'(t_r)*SEQ_W +: SEQ_W] : '0;
      if (req_v[r] && ok && en[t_r] && (s_r < lim) && (!pick_v || s_r < best)) begin
        pick_v   = 1'b1;
        pick_idx = IDX_W'(r);
        best     = s_r;
      end
    end
  end
endmodule

// File: rtl/srd_thread.sv
// Per-thread youngest tracker and multi-cycle flush sequencer.
module srd_thread
  import srd_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 6,
  parameter int RM    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ins_v,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             acc,
  input  logic [SEQ_W-1:0] acc_seq,
  input  logic [CNT_W-1:0] acc_drop,
  output logic [SEQ_W-1:0] yng_q,
  output tstate_e          state_q,
  output logic [CNT_W-1:0] rm_q
);
  localparam logic [CNT_W-1:0] RM_C = CNT_W'(RM);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] take;

  assign take = (rem_q > RM_C) ? RM_C : rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_IDLE;
      yng_q   <= '0;
      rem_q   <= '0;
      rm_q    <= '0;
    end else if (acc) begin
      yng_q   <= acc_seq;
      rem_q   <= acc_drop;
      rm_q    <= '0;
      state_q <= TS_FLUSH;
    end else if (state_q == TS_FLUSH) begin
      rm_q  <= take;
      rem_q <= rem_q - take;
      if (rem_q == take) state_q <= en ? TS_RUN : TS_IDLE;
    end else begin
      rm_q    <= '0;
      state_q <= en ? TS_RUN : TS_IDLE;
      if (state_q == TS_RUN && ins_v) yng_q <= ins_seq;
    end
  end

  // R3
  older_only_chk: assert property (@(posedge clk) disable iff (rst)
    acc |-> (acc_seq < yng_q));
  // R6
  flush_load_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (state_q == TS_FLUSH && yng_q == $past(acc_seq) && rm_q == '0));
  // R7
  rm_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rm_q != '0) |-> (rm_q <= RM_C && $past(state_q) == TS_FLUSH));
  // R8
  yng_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TS_FLUSH && !acc) |=> $stable(yng_q));
endmodule

// File: rtl/squash_redirect_unit.sv
module squash_redirect_unit
  import srd_pkg::*;
#(
  parameter int NT         = 2,
  parameter int NR         = 3,
  parameter int SEQ_W      = 16,
  parameter int TGT_W      = 32,
  parameter int CNT_W      = 6,
  parameter int RM_PER_CYC = 4,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int IDX_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int FC_W  = $clog2(NT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NT-1:0]       thr_en,
  input  logic [NT-1:0]       ins_v,
  input  logic [NT*SEQ_W-1:0] ins_seq,
  input  logic [NR-1:0]       req_v,
  input  logic [NR*TID_W-1:0] req_tid,
  input  logic [NR*SEQ_W-1:0] req_seq,
  input  logic [NR*TGT_W-1:0] req_tgt,
  input  logic [NR-1:0]       req_mis,
  input  logic [NR*CNT_W-1:0] req_drop,
  output logic                bc_v,
  output logic [TID_W-1:0]    bc_tid,
  output logic [SEQ_W-1:0]    bc_seq,
  output logic [TGT_W-1:0]    bc_tgt,
  output logic                bc_mis,
  output logic [NT*SEQ_W-1:0] youngest,
  output logic [NT-1:0]       flushing,
  output logic [NT*CNT_W-1:0] rm_num,
  output logic [FC_W-1:0]     flush_cnt,
  output logic                active
);
  logic             pick_v;
  logic [IDX_W-1:0] pick_idx;
  logic [TID_W-1:0] sel_tid;
  logic [SEQ_W-1:0] sel_seq;
  logic [CNT_W-1:0] sel_drop;
  logic [NT-1:0]    running;

  srd_pick #(.NT(NT), .NR(NR), .SEQ_W(SEQ_W), .TID_W(TID_W), .IDX_W(IDX_W)) u_pick (
    .req_v(req_v), .req_tid(req_tid), .req_seq(req_seq),
    .en(thr_en), .yng(youngest), .pick_v(pick_v), .pick_idx(pick_idx)
  );

  assign sel_tid  = req_tid[int'(pick_idx)*TID_W +: TID_W];
  assign sel_seq  = req_seq[int'(pick_idx)*SEQ_W +: SEQ_W];
  assign sel_drop = req_drop[int'(pick_idx)*CNT_W +: CNT_W];

  for (genvar t = 0; t < NT; t++) begin : g_thr
    tstate_e st;
    srd_thread #(.SEQ_W(SEQ_W), .CNT_W(CNT_W), .RM(RM_PER_CYC)) u_thr (
      .clk(clk), .rst(rst), .en(thr_en[t]),
      .ins_v(ins_v[t]), .ins_seq(ins_seq[t*SEQ_W +: SEQ_W]),
      .acc(pick_v && (int'(sel_tid) == t)), .acc_seq(sel_seq), .acc_drop(sel_drop),
      .yng_q(youngest[t*SEQ_W +: SEQ_W]), .state_q(st),
      .rm_q(rm_num[t*CNT_W +: CNT_W])
    );
    assign flushing[t] = (st == TS_FLUSH);
    assign running[t]  = (st == TS_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_v   <= 1'b0;
      bc_tid <= '0;
      bc_seq <= '0;
      bc_tgt <= '0;
      bc_mis <= 1'b0;
    end else begin
      bc_v <= pick_v;
      if (pick_v) begin
        bc_tid <= sel_tid;
        bc_seq <= sel_seq;
        bc_tgt <= req_tgt[int'(pick_idx)*TGT_W +: TGT_W];
        bc_mis <= req_mis[pick_idx];
      end
    end
  end

  always_comb begin
    flush_cnt = '0;
    for (int t = 0; t < NT; t++) flush_cnt = flush_cnt + FC_W'(flushing[t]);
  end

  assign active = (flush_cnt != '0) || (|running);
endmodule

// File: tb/squash_redirect_unit_tb.sv
`timescale 1ns/1ps
module squash_redirect_unit_tb;
  localparam int NT = 2, NR = 3, SEQ_W = 16, TGT_W = 32, CNT_W = 6, RM = 4;
  localparam int TID_W = 1, FC_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0]       thr_en = '0, ins_v = '0;
  logic [NT*SEQ_W-1:0] ins_seq = '0;
  logic [NR-1:0]       req_v = '0, req_mis = '0;
  logic [NR*TID_W-1:0] req_tid = '0;
  logic [NR*SEQ_W-1:0] req_seq = '0;
  logic [NR*TGT_W-1:0] req_tgt = '0;
  logic [NR*CNT_W-1:0] req_drop = '0;
  logic bc_v, bc_mis, active;
  logic [TID_W-1:0] bc_tid;
  logic [SEQ_W-1:0] bc_seq;
  logic [TGT_W-1:0] bc_tgt;
  logic [NT*SEQ_W-1:0] youngest;
  logic [NT-1:0] flushing;
  logic [NT*CNT_W-1:0] rm_num;
  logic [FC_W-1:0] flush_cnt;

  squash_redirect_unit #(.NT(NT), .NR(NR), .SEQ_W(SEQ_W), .TGT_W(TGT_W),
    .CNT_W(CNT_W), .RM_PER_CYC(RM)) u_dut (
    .clk(clk), .rst(rst), .thr_en(thr_en), .ins_v(ins_v), .ins_seq(ins_seq),
    .req_v(req_v), .req_tid(req_tid), .req_seq(req_seq), .req_tgt(req_tgt),
    .req_mis(req_mis), .req_drop(req_drop), .bc_v(bc_v), .bc_tid(bc_tid),
    .bc_seq(bc_seq), .bc_tgt(bc_tgt), .bc_mis(bc_mis), .youngest(youngest),
    .flushing(flushing), .rm_num(rm_num), .flush_cnt(flush_cnt), .active(active));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  // model state: 0 idle, 1 running, 2 flushing
  int m_yng[NT], m_st[NT], m_rem[NT], m_rm[NT];
  int m_bcv = 0, m_bct = 0, m_bcs = 0, m_bcm = 0;
  longint m_bcg = 0;
  int seqctr[NT];

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int take_of(int rem);
    return (rem > RM) ? RM : rem;
  endfunction

  // Next-state computed from the requirements using current drive values.
  task automatic model_step();
    int best, bseq, t, s;
    int n_yng[NT], n_st[NT], n_rem[NT], n_rm[NT];
    best = -1; bseq = 0;
    for (int r = 0; r < NR; r++) begin
      t = int'(req_tid[r*TID_W +: TID_W]);
      s = int'(req_seq[r*SEQ_W +: SEQ_W]);
      if (req_v[r] && thr_en[t] && s < m_yng[t] && (best < 0 || s < bseq)) begin
        best = r; bseq = s;
      end
    end
    for (int k = 0; k < NT; k++) begin
      n_yng[k] = m_yng[k]; n_st[k] = m_st[k]; n_rem[k] = m_rem[k]; n_rm[k] = 0;
      if (best >= 0 && int'(req_tid[best*TID_W +: TID_W]) == k) begin
        n_yng[k] = bseq; n_rem[k] = int'(req_drop[best*CNT_W +: CNT_W]); n_st[k] = 2;
      end else if (m_st[k] == 2) begin
        n_rm[k] = take_of(m_rem[k]);
        n_rem[k] = m_rem[k] - n_rm[k];
        if (n_rem[k] == 0) n_st[k] = thr_en[k] ? 1 : 0;
      end else begin
        n_st[k] = thr_en[k] ? 1 : 0;
        if (m_st[k] == 1 && ins_v[k]) n_yng[k] = int'(ins_seq[k*SEQ_W +: SEQ_W]);
      end
    end
    for (int k = 0; k < NT; k++) begin
      m_yng[k] = n_yng[k]; m_st[k] = n_st[k]; m_rem[k] = n_rem[k]; m_rm[k] = n_rm[k];
    end
    m_bcv = (best >= 0) ? 1 : 0;
    if (best >= 0) begin
      m_bct = int'(req_tid[best*TID_W +: TID_W]);
      m_bcs = bseq;
      m_bcg = longint'(req_tgt[best*TGT_W +: TGT_W]);
      m_bcm = int'(req_mis[best]);
    end
  endtask

  task automatic compare();
    int fc, any_run;
    fc = 0; any_run = 0;
    for (int k = 0; k < NT; k++) begin
      chk("R2/R6 youngest", youngest[k*SEQ_W +: SEQ_W], m_yng[k]);
      chk("R6/R8/R11 flushing", flushing[k], (m_st[k] == 2) ? 1 : 0);
      chk("R7 rm_num", rm_num[k*CNT_W +: CNT_W], m_rm[k]);
      if (m_st[k] == 2) fc++;
      if (m_st[k] == 1) any_run = 1;
    end
    chk("R3/R4 bc_v", bc_v, m_bcv);
    if (m_bcv != 0) begin
      chk("R4/R5 bc_tid", bc_tid, m_bct);
      chk("R4/R5 bc_seq", bc_seq, m_bcs);
      chk("R5 bc_tgt", bc_tgt, m_bcg);
      chk("R5 bc_mis", bc_mis, m_bcm);
    end
    chk("R10 flush_cnt", flush_cnt, fc);
    chk("R10 active", active, (fc != 0 || any_run != 0) ? 1 : 0);
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    compare();
    req_v = '0;
    ins_v = '0;
  endtask

  task automatic set_req(int r, int tid, int seq, int drop, longint tgt, int mis);
    req_v[r] = 1'b1;
    req_tid[r*TID_W +: TID_W] = TID_W'(tid);
    req_seq[r*SEQ_W +: SEQ_W] = SEQ_W'(seq);
    req_drop[r*CNT_W +: CNT_W] = CNT_W'(drop);
    req_tgt[r*TGT_W +: TGT_W] = TGT_W'(tgt);
    req_mis[r] = mis[0];
  endtask

  task automatic insert(int t, int seq);
    ins_v[t] = 1'b1;
    ins_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(seq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NT; k++) begin
      m_yng[k] = 0; m_st[k] = 0; m_rem[k] = 0; m_rm[k] = 0; seqctr[k] = 1000 * (k + 1);
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    compare();
    // R11: enable both threads -> running
    thr_en = '1;
    cycle();
    // R3: youngest still 0, so nothing is older -> ignored
    set_req(0, 0, 0, 3, 32'h11, 1);
    cycle();
    // R2: inserts on running threads
    insert(0, 100); insert(1, 200);
    cycle();
    // R4: smallest sequence among eligible wins (r2, seq 40), drop 9 -> 4,4,1 (R7)
    set_req(0, 0, 50, 2, 32'hA0, 0);
    set_req(1, 1, 50, 2, 32'hA1, 1);
    set_req(2, 0, 40, 9, 32'hA2, 1);
    cycle();
    // R2: insert during flush ignored
    insert(0, 300);
    cycle();
    // R9: older redirect during flush restarts it
    set_req(1, 0, 30, 5, 32'hB1, 0);
    cycle();
    repeat (4) cycle();
    // R4: tie on seq 60 for thread 1 -> lowest index wins
    set_req(1, 1, 60, 0, 32'hC1, 1);
    set_req(2, 1, 60, 4, 32'hC2, 0);
    cycle();
    cycle();
    // R3/R11: disabled thread ignores redirects and goes idle; R8 ends in idle
    thr_en[0] = 1'b0;
    set_req(0, 0, 1, 2, 32'hD0, 1);
    cycle();
    set_req(0, 1, 10, 8, 32'hD1, 0);
    cycle();
    thr_en[1] = 1'b0;
    repeat (3) cycle();
    thr_en = '1;
    cycle();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      thr_en = '1;
      if ($urandom % 20 == 0) thr_en[$urandom % NT] = 1'b0;
      for (int k = 0; k < NT; k++) begin
        if ($urandom % 2 == 0) begin
          seqctr[k] = seqctr[k] + 1 + int'($urandom % 3);
          insert(k, seqctr[k] & 16'hFFFF);
        end
      end
      for (int r = 0; r < NR; r++) begin
        if ($urandom % 4 == 0) begin
          int t;
          t = int'($urandom % NT);
          set_req(r, t, (m_yng[t] + int'($urandom % 8) - 5) & 16'hFFFF,
                  int'($urandom % 14), longint'($urandom), int'($urandom % 2));
        end
      end
      cycle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule